// File: doc/BRIEF.md
# Two-wire serial EEPROM slave engine

This block is the target side of a byte-addressed serial memory on a two-wire bus. It samples the bus clock and data lines with the system clock and finds start and stop conditions. It takes in a device select byte and checks it against three strap inputs. It then takes two word-address bytes and runs single-byte writes, page writes, current-address reads, random reads and sequential reads against an internal byte array. The data line is driven open-drain: the block only ever pulls it low, through one output.

Write data is collected in a page-sized staging buffer. Nothing reaches the array until a stop condition closes the transfer. That stop starts a self-timed busy interval, and during it the block ignores the bus and does not acknowledge its own address. A master can therefore poll for the end of the write. A write-protect input stops the array from being modified.

The array holds 2^WORD_AW bytes. The default keeps elaboration small. WORD_AW = 14 gives the full 16K x 8 organisation. PAGE_AW sets the page size, BUSY_CYC sets the busy interval in system clocks, and SYNC_STAGES sets the input synchroniser depth.

Top module: `eep_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) seen in any state other than busy begins a new transfer expecting a device select byte with the bit counter cleared, even if it arrives in the middle of a byte.
- R2: Bytes are sent MSB first. A device select byte whose upper four bits are 1010 and whose next three bits equal strap_i is acknowledged: SDA is held low from the SCL fall after its eighth bit until the SCL fall after the ninth clock. Bit 0 is the read flag (1 = read). On any other value SDA stays released and the block idles until the next start. Out of reset, SDA is released.
- R3: A write transfer carries a high address byte and then a low address byte, and each is acknowledged. The word address is {high[5:0], low} truncated to WORD_AW bits, so high[7:6] never affect the location.
- R4: Every data byte of a write transfer is acknowledged and is staged for the current address. After each byte only the low PAGE_AW address bits advance, wrapping from the last byte of the page to its first byte.
- R5: Staged bytes are written to the array only when a stop condition (SDA rising while SCL is high) follows at least one fully acknowledged data byte. A stop with no data byte, or a start that interrupts the write, starts no write and no busy interval, and it discards the staged bytes.
- R6: For BUSY_CYC clocks after a committing stop, the block ignores the bus and does not acknowledge a device select byte. After that interval it acknowledges again.
- R7: If wp_i is high when the committing stop arrives, the array is left unchanged. The busy interval still runs.
- R8: A current-address read returns the byte at the internal address counter. After each byte read the counter advances by one, wrapping from the last array byte to byte 0. After a write it holds the last written address plus one, within the page.
- R9: A random read (write select, two address bytes, repeated start, read select) returns the byte at the given address.
- R10: In a read, a master acknowledge (SDA low on the ninth clock) makes the block send the next sequential byte. A missing acknowledge releases the bus and ends the read.
- R11: The block changes its SDA drive only after an SCL falling edge, never while SCL is high. It samples SDA on SCL rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_i | input | 3 | Hardwired device select bits |
| wp_i | input | 1 | Write protect, high blocks array updates |
| sda_drive_low_o | output | 1 | High pulls the data line low (open-drain) |

## Verification
The assertions check on every cycle the following rules:
- The SDA drive changes only after a sampled SCL low.
- The block never drives during the busy interval.
- Busy is entered only from a stop.
- A start resets the byte framing.
- An acknowledge of a select byte happens only on a strap match.
- Staged writes never leave their page.

Only the bench scenarios can show what reaches the array and when:
- Page wrap-around overwriting.
- Discarded writes after an abort or under write protect.
- The ignored top address bits.
- Address-counter continuity across current-address and sequential reads, including the wrap at the end of the array.
- Poll responses before and after the busy interval.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA,
        ST_BUSY
    } eep_state_t;

    // Sampled bus levels and the events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] sel, input logic [2:0] strap);
        return (sel[7:4] == DEV_TYPE) && (sel[3:1] == strap);
    endfunction

    function automatic logic [13:0] word_addr(input logic [7:0] hi, input logic [7:0] lo);
        return {hi[5:0], lo};
    endfunction

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync
    import eep_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        ev_o.scl   = scl_s;
        ev_o.sda   = sda_s;
        ev_o.rise  = scl_s & ~scl_d;
        ev_o.fall  = ~scl_s & scl_d;
        ev_o.start = scl_s & scl_d & sda_d & ~sda_s;
        ev_o.stop  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells[waddr_i] <= wdata_i;
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int WORD_AW  = 11,
    parameter int PAGE_AW  = 6,
    parameter int BUSY_CYC = 2000
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_ev_t            ev_i,
    input  logic [2:0]         strap_i,
    input  logic               wp_i,
    input  logic [7:0]         mem_rdata_i,
    output logic [WORD_AW-1:0] mem_raddr_o,
    output logic               mem_we_o,
    output logic [WORD_AW-1:0] mem_waddr_o,
    output logic [7:0]         mem_wdata_o,
    output logic               sda_low_o
);

    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int BW         = $clog2(BUSY_CYC + 1);
    localparam logic [BW-1:0] BUSY_LAST = BW'(BUSY_CYC - 1);
    localparam logic [BW-1:0] PAGE_LIM  = BW'(PAGE_BYTES);

    eep_state_t            state_q;
    logic [3:0]            bitcnt_q;
    logic [7:0]            sh_q;
    logic [7:0]            txb_q;
    logic [7:0]            hi_q;
    logic [WORD_AW-1:0]    ptr_q;
    logic [PAGE_BYTES-1:0] pval_q;
    logic [7:0]            pbuf_q [PAGE_BYTES];
    logic                  has_data_q;
    logic                  wp_lat_q;
    logic                  sda_low_q;
    logic [BW-1:0]         busy_cnt_q;

    logic [PAGE_AW-1:0]    slot;
    logic [PAGE_AW-1:0]    commit_slot;
    logic [2:0]            tx_idx;
    logic                  active;
    logic                  store_en;

    assign slot        = ptr_q[PAGE_AW-1:0];
    assign commit_slot = busy_cnt_q[PAGE_AW-1:0];
    assign tx_idx      = 3'(4'd7 - bitcnt_q);
    assign active      = (state_q == ST_DEV) || (state_q == ST_AHI) || (state_q == ST_ALO) ||
                         (state_q == ST_WDATA) || (state_q == ST_RDATA);
    assign store_en    = (state_q == ST_WDATA) && ev_i.fall && (bitcnt_q == 4'd8);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            bitcnt_q   <= 4'd0;
            sh_q       <= 8'd0;
            txb_q      <= 8'd0;
            hi_q       <= 8'd0;
            ptr_q      <= '0;
            pval_q     <= '0;
            has_data_q <= 1'b0;
            wp_lat_q   <= 1'b0;
            sda_low_q  <= 1'b0;
            busy_cnt_q <= '0;
        end else if (state_q == ST_BUSY) begin
            busy_cnt_q <= busy_cnt_q + 1'b1;
            if (busy_cnt_q == BUSY_LAST) begin
                state_q    <= ST_IDLE;
                pval_q     <= '0;
                has_data_q <= 1'b0;
            end
        end else if (ev_i.start) begin
            state_q    <= ST_DEV;
            bitcnt_q   <= 4'd0;
            sda_low_q  <= 1'b0;
            pval_q     <= '0;
            has_data_q <= 1'b0;
        end else if (ev_i.stop) begin
            sda_low_q <= 1'b0;
            bitcnt_q  <= 4'd0;
            if (state_q == ST_WDATA && has_data_q) begin
                state_q    <= ST_BUSY;
                busy_cnt_q <= '0;
                wp_lat_q   <= wp_i;
            end else begin
                state_q <= ST_IDLE;
            end
        end else if (active && ev_i.rise) begin
            if (bitcnt_q < 4'd8) begin
                sh_q     <= {sh_q[6:0], ev_i.sda};
                bitcnt_q <= bitcnt_q + 4'd1;
            end else if (bitcnt_q == 4'd8) begin
                bitcnt_q <= 4'd9;
                if (state_q == ST_RDATA && ev_i.sda) state_q <= ST_IDLE;
            end
        end else if (active && ev_i.fall) begin
            if (bitcnt_q == 4'd8) begin
                case (state_q)
                    ST_DEV: begin
                        if (dev_match(sh_q, strap_i)) sda_low_q <= 1'b1;
                        else                          state_q   <= ST_IDLE;
                    end
                    ST_AHI: begin
                        hi_q      <= sh_q;
                        sda_low_q <= 1'b1;
                    end
                    ST_ALO: begin
                        ptr_q     <= WORD_AW'(word_addr(hi_q, sh_q));
                        sda_low_q <= 1'b1;
                    end
                    ST_WDATA: begin
                        pval_q[slot] <= 1'b1;
                        has_data_q   <= 1'b1;
                        ptr_q        <= {ptr_q[WORD_AW-1:PAGE_AW], slot + 1'b1};
                        sda_low_q    <= 1'b1;
                    end
                    ST_RDATA: begin
                        sda_low_q <= 1'b0;
                        ptr_q     <= ptr_q + 1'b1;
                    end
                    default: ;
                endcase
            end else if (bitcnt_q == 4'd9) begin
                bitcnt_q <= 4'd0;
                case (state_q)
                    ST_DEV: begin
                        if (sh_q[0]) begin
                            state_q   <= ST_RDATA;
                            txb_q     <= mem_rdata_i;
                            sda_low_q <= ~mem_rdata_i[7];
                        end else begin
                            state_q   <= ST_AHI;
                            sda_low_q <= 1'b0;
                        end
                    end
                    ST_AHI: begin
                        state_q   <= ST_ALO;
                        sda_low_q <= 1'b0;
                    end
                    ST_ALO: begin
                        state_q   <= ST_WDATA;
                        sda_low_q <= 1'b0;
                    end
                    ST_WDATA: sda_low_q <= 1'b0;
                    ST_RDATA: begin
                        txb_q     <= mem_rdata_i;
                        sda_low_q <= ~mem_rdata_i[7];
                    end
                    default: ;
                endcase
            end else if (state_q == ST_RDATA && bitcnt_q != 4'd0) begin
                sda_low_q <= ~txb_q[tx_idx];
            end
        end
    end

    // Staging buffer data, no reset needed: validity lives in pval_q
    always_ff @(posedge clk) begin
        if (store_en) pbuf_q[slot] <= sh_q;
    end

    assign mem_raddr_o = ptr_q;
    assign mem_we_o    = (state_q == ST_BUSY) && (busy_cnt_q < PAGE_LIM) &&
                         pval_q[commit_slot] && !wp_lat_q;
    assign mem_waddr_o = {ptr_q[WORD_AW-1:PAGE_AW], commit_slot};
    assign mem_wdata_o = pbuf_q[commit_slot];
    assign sda_low_o   = sda_low_q;

    // R11
    sda_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low_q) |-> $past(!ev_i.scl));

    // R6
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSY) |-> !sda_low_q);

    // R5
    busy_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_BUSY) |-> $past(ev_i.stop));

    // R1
    start_resync_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ev_i.start) && $past(state_q != ST_BUSY)) |-> (state_q == ST_DEV && bitcnt_q == 4'd0));

    // R2
    select_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_low_q) && state_q == ST_DEV) |-> dev_match(sh_q, strap_i));

    // R4
    page_stay_chk: assert property (@(posedge clk) disable iff (rst)
        $past(store_en) |-> (ptr_q[WORD_AW-1:PAGE_AW] == $past(ptr_q[WORD_AW-1:PAGE_AW])));

endmodule

// File: rtl/eep_slave.sv
module eep_slave
    import eep_pkg::*;
#(
    parameter int WORD_AW     = 11,
    parameter int PAGE_AW     = 6,
    parameter int BUSY_CYC    = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_drive_low_o
);

    bus_ev_t            ev;
    logic [WORD_AW-1:0] raddr;
    logic [WORD_AW-1:0] waddr;
    logic [7:0]         rdata;
    logic [7:0]         wdata;
    logic               we;

    eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    eep_ctrl #(.WORD_AW(WORD_AW), .PAGE_AW(PAGE_AW), .BUSY_CYC(BUSY_CYC)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ev_i        (ev),
        .strap_i     (strap_i),
        .wp_i        (wp_i),
        .mem_rdata_i (rdata),
        .mem_raddr_o (raddr),
        .mem_we_o    (we),
        .mem_waddr_o (waddr),
        .mem_wdata_o (wdata),
        .sda_low_o   (sda_drive_low_o)
    );

    eep_array #(.AW(WORD_AW)) u_array (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

endmodule

// File: tb/eep_slave_bench.sv
module eep_slave_bench;

    localparam int BUSY = 600;
    localparam int Q    = 4;
    localparam logic [7:0] SEL_W = 8'hAA;
    localparam logic [7:0] SEL_R = 8'hAB;

    logic       clk   = 1'b0;
    logic       rst   = 1'b1;
    logic       scl   = 1'b1;
    logic       m_sda = 1'b1;
    logic       wp    = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       sda_low;
    logic       sda_bus;

    assign sda_bus = m_sda & ~sda_low;

    always #2 clk = ~clk;

    eep_slave #(.WORD_AW(11), .PAGE_AW(6), .BUSY_CYC(BUSY), .SYNC_STAGES(2)) u_eep_slave (
        .clk             (clk),
        .rst             (rst),
        .scl_i           (scl),
        .sda_i           (sda_bus),
        .strap_i         (strap),
        .wp_i            (wp),
        .sda_drive_low_o (sda_low)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    int          edge_viol = 0;
    logic        prev_low = 1'b0;
    logic [7:0]  exp_q [$];
    logic [7:0]  obs_q [$];
    string       tag_q [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R11 watcher: slave drive must not move while SCL is high
    always @(negedge clk) begin
        if (!rst && sda_low !== prev_low && scl === 1'b1) edge_viol++;
        prev_low = sda_low;
    end

    // Scoreboard monitor
    initial begin
        logic [7:0] o;
        logic [7:0] e;
        string      t;
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(o == e, t, int'(o), int'(e));
            end
        end
    end

    task automatic start_c();
        m_sda = 1'b1; tick(Q);
        scl   = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic stop_c();
        m_sda = 1'b0; tick(Q);
        scl   = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    tick(Q);
        scl   = 1'b1; tick(2 * Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; tick(Q);
        scl   = 1'b1; tick(Q);
        acked = (sda_bus == 1'b0);
        tick(Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] v);
        v = 8'd0;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; tick(Q);
            scl   = 1'b1; tick(Q);
            v     = {v[6:0], sda_bus};
            tick(Q);
            scl   = 1'b0; tick(Q);
        end
        send_bit(~mack);
    endtask

    task automatic put_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit a;
        send_byte(b, a);
        check(a == exp_ack, req, int'(a), int'(exp_ack));
    endtask

    task automatic wr_setup(input logic [7:0] hi, input logic [7:0] lo, input string req);
        start_c();
        put_byte(SEL_W, 1'b1, req);
        put_byte(hi, 1'b1, req);
        put_byte(lo, 1'b1, req);
    endtask

    task automatic write_seq(input logic [7:0] hi, input logic [7:0] lo, input logic [31:0] d,
                             input int n, input bit wait_done, input string req);
        wr_setup(hi, lo, req);
        for (int i = 0; i < n; i++) put_byte(8'(d >> (8 * (n - 1 - i))), 1'b1, req);
        stop_c();
        if (wait_done) tick(BUSY + 40);
    endtask

    task automatic read_seq(input logic [7:0] hi, input logic [7:0] lo, input logic [31:0] d,
                            input int n, input string req);
        logic [7:0] v;
        wr_setup(hi, lo, req);
        start_c();
        put_byte(SEL_R, 1'b1, req);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(8'(d >> (8 * (n - 1 - i))));
            tag_q.push_back(req);
            recv_byte(i < n - 1, v);
            obs_q.push_back(v);
        end
        stop_c();
        tick(4);
    endtask

    task automatic cur_read(input logic [7:0] e, input string req);
        logic [7:0] v;
        start_c();
        put_byte(SEL_R, 1'b1, req);
        exp_q.push_back(e);
        tag_q.push_back(req);
        recv_byte(1'b0, v);
        obs_q.push_back(v);
        stop_c();
        tick(4);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        tick(10);
        rst = 1'b0;
        tick(10);
        check(sda_low == 1'b0, "R2 reset releases SDA", int'(sda_low), 0);

        // R2: wrong strap bits are not acknowledged
        start_c();
        put_byte(8'hA2, 1'b0, "R2 select mismatch nack");
        stop_c();
        tick(8);

        // R4 byte write, R6 polling during and after the busy interval
        write_seq(8'h01, 8'h23, 32'h5A, 1, 1'b0, "R4 byte write ack");
        tick(20);
        start_c();
        put_byte(SEL_W, 1'b0, "R6 select nack while busy");
        stop_c();
        tick(BUSY + 40);
        start_c();
        put_byte(SEL_W, 1'b1, "R6 select ack after busy");
        stop_c();
        tick(8);

        read_seq(8'h01, 8'h23, 32'h5A, 1, "R9 random read");

        // R10 sequential read of a page write
        write_seq(8'h02, 8'h00, 32'h11223344, 4, 1'b1, "R4 page write ack");
        read_seq(8'h02, 8'h00, 32'h11223344, 4, "R10 sequential read");

        // R8 current address after a single read
        read_seq(8'h02, 8'h01, 32'h22, 1, "R9 random read mid page");
        cur_read(8'h33, "R8 current address read");

        // R4 page roll-over
        write_seq(8'h02, 8'h3E, 32'hA0A1A2A3, 4, 1'b1, "R4 wrap write ack");
        read_seq(8'h02, 8'h00, 32'hA2A3, 2, "R4 page wrap head");
        read_seq(8'h02, 8'h3E, 32'hA0A1, 2, "R4 page wrap tail");
        read_seq(8'h02, 8'h02, 32'h33, 1, "R4 page wrap leaves rest");

        // R3 top bits of the high address byte ignored
        write_seq(8'hC1, 8'h50, 32'h77, 1, 1'b1, "R3 address ack");
        read_seq(8'h01, 8'h50, 32'h77, 1, "R3 top bits ignored");

        // R7 write protect
        wp = 1'b1;
        write_seq(8'h01, 8'h50, 32'h99, 1, 1'b1, "R7 protected write ack");
        wp = 1'b0;
        read_seq(8'h01, 8'h50, 32'h77, 1, "R7 protected location unchanged");

        // R5 address-only write starts no busy interval
        wr_setup(8'h01, 8'h50, "R5 address only");
        stop_c();
        tick(8);
        start_c();
        put_byte(SEL_W, 1'b1, "R5 no busy after address-only stop");
        stop_c();
        tick(8);

        // R5 start during data phase discards staged bytes
        wr_setup(8'h01, 8'h50, "R5 aborted write");
        put_byte(8'h12, 1'b1, "R5 aborted write data ack");
        start_c();
        put_byte(SEL_W, 1'b1, "R5 repeated start select");
        stop_c();
        tick(8);
        start_c();
        put_byte(SEL_W, 1'b1, "R5 no busy after aborted write");
        stop_c();
        tick(8);
        read_seq(8'h01, 8'h50, 32'h77, 1, "R5 aborted data not written");

        // R1 start in the middle of a byte resynchronises framing
        start_c();
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        start_c();
        put_byte(SEL_W, 1'b1, "R1 select ack after mid-byte start");
        stop_c();
        tick(8);

        // R8 read wrap from last array byte to byte 0
        write_seq(8'h07, 8'hFF, 32'hE1, 1, 1'b1, "R8 last byte write");
        write_seq(8'h00, 8'h00, 32'hE2, 1, 1'b1, "R8 first byte write");
        read_seq(8'h07, 8'hFF, 32'hE1E2, 2, "R8 array wrap read");

        check(edge_viol == 0, "R11 drive changes only with SCL low", edge_viol, 0);
        tick(10);
        check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule